// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a clocked host and a 2048 x 8 asynchronous static RAM. The host issues one read or write command at a time through a valid/ready handshake. The controller then drives the RAM's address, its active-low chip select, write strobe and output enable, and its data lines. It does this in a sequence whose phase lengths are whole clock cycles. Every phase length is derived by rounding a nanosecond limit up to the clock period given as a parameter, so the same RTL meets the RAM's minimum timings at any clock rate.

A command is taken only while the controller is idle. The address and write data are latched at that moment. Exactly one `done` pulse ends each command; for a read, `rd_data` holds the byte fetched by that read. The RAM's output enable and the controller's own data driver are never active together, and after every read the driver stays off long enough for the RAM to release the lines. A write-protect input from the supply monitor turns any write into an immediate error response, with no write strobe issued.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dout_en`, `done` and `done_err` are 0, and `req_ready` is 1.
- R2: An accepted read holds `mem_ce_n` and `mem_oe_n` low, with `mem_we_n` high, for exactly RD = max(ceil(100/T), ceil(50/T)) cycles, where T is `CLK_NS`. RD is 10 at T = 10. The strobe starts in the cycle after acceptance, and `mem_addr` does not change while `mem_ce_n` is low.
- R3: For a read, `done` is high for one cycle, exactly RD+1 cycles after the accepting clock edge. `done_err` is 0, and `rd_data` equals the byte the RAM drove on `mem_din` in the last strobe cycle.
- R4: An accepted write spends one setup cycle with both strobes high and the data driver on. It then pulls `mem_ce_n` and `mem_we_n` low together for exactly WP = max(ceil(75/T), ceil(40/T)) cycles, which is 8 at T = 10, with `mem_oe_n` high throughout.
- R5: During a write, `mem_dout_en` is 1 from the setup cycle through a recovery phase of REC = max(ceil(10/T), ceil(100/T) - WP - 1) cycles after the strobes rise. This covers the cycle in which `mem_we_n` rises. `done` pulses, with `done_err` 0, exactly WP+REC+2 cycles after the accepting edge (11 at T = 10).
- R6: `mem_we_n` and `mem_oe_n` are never low at the same time, and `mem_dout_en` is never 1 while `mem_oe_n` is low.
- R7: After a read, `mem_dout_en` stays 0 for more than TA = max(ceil(35/T), ceil(100/T) - RD) cycles after `mem_oe_n` rises (TA is 4 at T = 10). `req_ready` returns exactly TA cycles after the read's `done` cycle.
- R8: `req_ready` is 1 only while idle. A write is ready again in its `done` cycle. `req_valid` while `req_ready` is 0 is ignored: it causes no RAM write and no extra `done`.
- R9: A write accepted while `wprot` is 1 gives `done` and `done_err` both 1 in the cycle after acceptance. It issues no `mem_we_n` pulse and leaves the RAM unchanged. A read is unaffected by `wprot` (`done_err` 0).
- R10: Address and write data are captured at acceptance. Later changes on `req_addr` and `req_wdata` do not affect the command in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host command present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Command address |
| req_wdata | input | DATA_W | Write data |
| wprot | input | 1 | Write-protect from the supply monitor |
| req_ready | output | 1 | Controller idle; command accepted when valid |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | With `done`: write refused by protection |
| rd_data | output | DATA_W | Read result, valid with `done` |
| mem_addr | output | ADDR_W | RAM address lines |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dout | output | DATA_W | Data toward the RAM |
| mem_dout_en | output | 1 | Drive enable for `mem_dout` |
| mem_din | input | DATA_W | Data from the RAM |

## Verification
At the default 10 ns period, a read's `done` and `rd_data` are due 11 cycles after the accepting edge, and `req_ready` follows 4 cycles later. A write's `done` is also due 11 cycles after acceptance, and a protected write's error response comes 1 cycle after. The bench computes these counts from the nanosecond limits with its own rounding functions. It samples on falling edges and counts falling edges from the accepting edge until `done`, then compares the count with the expected value rather than waiting loosely. Strobe widths, the recovery drive and the post-read quiet gap are measured by a falling-edge monitor against the same computed counts.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_SETUP   = 3'd1,
        PH_STROBE  = 3'd2,
        PH_RECOVER = 3'd3,
        PH_TURN    = 3'd4
    } phase_e;

    // Whole cycles needed to cover ns nanoseconds, at least one.
    function automatic int ns2cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_seq_phase.sv
module sram_seq_phase
    import sram_seq_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int SU_CYC  = 1,
    parameter int RD_CYC  = 10,
    parameter int WP_CYC  = 8,
    parameter int REC_CYC = 1,
    parameter int TA_CYC  = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   start_wr,
    output phase_e phase_q,
    output phase_e phase_d,
    output logic   wr_q,
    output logic   wr_d,
    output logic   last
);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic             wr;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
        case (s_q.ph)
            PH_IDLE: begin
                s_d.cnt = '0;
                if (start) begin
                    s_d.wr = start_wr;
                    if (start_wr) begin
                        s_d.ph  = PH_SETUP;
                        s_d.cnt = CNT_W'(SU_CYC - 1);
                    end else begin
                        s_d.ph  = PH_STROBE;
                        s_d.cnt = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            PH_SETUP: begin
                if (s_q.cnt == '0) begin
                    s_d.ph  = PH_STROBE;
                    s_d.cnt = CNT_W'(WP_CYC - 1);
                end
            end
            PH_STROBE: begin
                if (s_q.cnt == '0) begin
                    if (s_q.wr) begin
                        s_d.ph  = PH_RECOVER;
                        s_d.cnt = CNT_W'(REC_CYC - 1);
                    end else begin
                        s_d.ph  = PH_TURN;
                        s_d.cnt = CNT_W'(TA_CYC - 1);
                    end
                end
            end
            PH_RECOVER, PH_TURN: begin
                if (s_q.cnt == '0) begin
                    s_d.ph = PH_IDLE;
                end
            end
            default: begin
                s_d.ph  = PH_IDLE;
                s_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, cnt: '0, wr: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_q = s_q.ph;
    assign phase_d = s_d.ph;
    assign wr_q    = s_q.wr;
    assign wr_d    = s_d.wr;
    assign last    = (s_q.cnt == '0);

endmodule

// File: rtl/sram_seq_pins.sv
module sram_seq_pins
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase_q,
    input  phase_e            phase_d,
    input  logic              wr_q,
    input  logic              wr_d,
    input  logic              last,
    input  logic              start,
    input  logic              reject,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_din,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              done_err
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              ce_n;
        logic              we_n;
        logic              oe_n;
        logic              den;
        logic              done;
        logic              err;
    } pin_t;

    pin_t p_d, p_q;
    logic strobe_d;
    logic drive_ph_d;

    always_comb begin
        strobe_d   = (phase_d == PH_STROBE);
        drive_ph_d = (phase_d == PH_SETUP) || strobe_d || (phase_d == PH_RECOVER);

        p_d      = p_q;
        p_d.done = 1'b0;
        p_d.err  = 1'b0;
        p_d.ce_n = !strobe_d;
        p_d.we_n = !(strobe_d && wr_d);
        p_d.oe_n = !(strobe_d && !wr_d);
        p_d.den  = wr_d && drive_ph_d;

        if (start) begin
            p_d.addr  = req_addr;
            p_d.wdata = req_wdata;
        end
        if (phase_q == PH_STROBE && last && !wr_q) begin
            p_d.rdata = mem_din;
            p_d.done  = 1'b1;
        end
        if (phase_q == PH_RECOVER && last) begin
            p_d.done = 1'b1;
        end
        if (reject) begin
            p_d.done = 1'b1;
            p_d.err  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '{addr: '0, wdata: '0, rdata: '0, ce_n: 1'b1, we_n: 1'b1,
                     oe_n: 1'b1, den: 1'b0, done: 1'b0, err: 1'b0};
        end else begin
            p_q <= p_d;
        end
    end

    assign mem_addr    = p_q.addr;
    assign mem_dout    = p_q.wdata;
    assign mem_dout_en = p_q.den;
    assign mem_ce_n    = p_q.ce_n;
    assign mem_we_n    = p_q.we_n;
    assign mem_oe_n    = p_q.oe_n;
    assign rd_data     = p_q.rdata;
    assign done        = p_q.done;
    assign done_err    = p_q.err;

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int CLK_NS   = 10,
    parameter int ADDR_W   = 11,
    parameter int DATA_W   = 8,
    parameter int T_AS_NS  = 0,
    parameter int T_ACC_NS = 100,
    parameter int T_OE_NS  = 50,
    parameter int T_CO_NS  = 100,
    parameter int T_RC_NS  = 100,
    parameter int T_HZ_NS  = 35,
    parameter int T_WP_NS  = 75,
    parameter int T_DS_NS  = 40,
    parameter int T_WC_NS  = 100,
    parameter int T_WR_NS  = 10,
    parameter int T_DH_NS  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              wprot,
    output logic              req_ready,
    output logic              done,
    output logic              done_err,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    input  logic [DATA_W-1:0] mem_din
);

    localparam int SU_CYC  = ns2cyc(T_AS_NS, CLK_NS);
    localparam int RD_CYC  = imax(imax(ns2cyc(T_ACC_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS)),
                                  ns2cyc(T_CO_NS, CLK_NS));
    localparam int TA_CYC  = imax(ns2cyc(T_HZ_NS, CLK_NS), ns2cyc(T_RC_NS, CLK_NS) - RD_CYC);
    localparam int WP_CYC  = imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DS_NS, CLK_NS));
    localparam int REC_CYC = imax(imax(ns2cyc(T_WR_NS, CLK_NS), ns2cyc(T_DH_NS, CLK_NS)),
                                  ns2cyc(T_WC_NS, CLK_NS) - WP_CYC - SU_CYC);
    localparam int MAX_CYC = imax(imax(SU_CYC, RD_CYC), imax(imax(TA_CYC, WP_CYC), REC_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    phase_e phase_q, phase_d;
    logic   wr_q, wr_d, last;
    logic   accept, reject, start;

    assign req_ready = (phase_q == PH_IDLE);
    assign accept    = req_valid && req_ready;
    assign reject    = accept && req_write && wprot;
    assign start     = accept && !reject;

    sram_seq_phase #(
        .CNT_W  (CNT_W),
        .SU_CYC (SU_CYC),
        .RD_CYC (RD_CYC),
        .WP_CYC (WP_CYC),
        .REC_CYC(REC_CYC),
        .TA_CYC (TA_CYC)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .start_wr(req_write),
        .phase_q (phase_q),
        .phase_d (phase_d),
        .wr_q    (wr_q),
        .wr_d    (wr_d),
        .last    (last)
    );

    sram_seq_pins #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_q    (phase_q),
        .phase_d    (phase_d),
        .wr_q       (wr_q),
        .wr_d       (wr_d),
        .last       (last),
        .start      (start),
        .reject     (reject),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .mem_din    (mem_din),
        .mem_addr   (mem_addr),
        .mem_dout   (mem_dout),
        .mem_dout_en(mem_dout_en),
        .mem_ce_n   (mem_ce_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .rd_data    (rd_data),
        .done       (done),
        .done_err   (done_err)
    );

endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk #(
    parameter int ADDR_W = 11,
    parameter int RD_CYC = 10,
    parameter int WP_CYC = 8,
    parameter int TA_CYC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_ready,
    input logic              wprot,
    input logic              done,
    input logic              done_err,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dout_en,
    input logic [ADDR_W-1:0] mem_addr
);

    logic [15:0] ce_run;
    logic [15:0] since_oe;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_run   <= '0;
            since_oe <= 16'hFFFF;
        end else begin
            ce_run <= (!mem_ce_n && ce_run != 16'hFFFF) ? ce_run + 16'd1
                    : (!mem_ce_n ? ce_run : 16'd0);
            if (!mem_oe_n) begin
                since_oe <= '0;
            end else if (since_oe != 16'hFFFF) begin
                since_oe <= since_oe + 16'd1;
            end
        end
    end

    // R6: write strobe and output enable never overlap
    a_r6_we_oe_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));

    // R6: host driver off while the RAM may drive
    a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dout_en |-> mem_oe_n);

    // R7: quiet gap after a read before driving
    a_r7_turn_gap: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dout_en |-> (since_oe > 16'(TA_CYC)));

    // R2: address frozen while selected
    a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

    // R2: read strobe width
    a_r2_read_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_ce_n) && $past(mem_we_n)) |-> (ce_run == 16'(RD_CYC)));

    // R4: write strobe width
    a_r4_write_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_ce_n) && !$past(mem_we_n)) |-> (ce_run == 16'(WP_CYC)));

    // R4: write strobe starts with select and with data on the lines
    a_r4_we_with_ce: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($fell(mem_ce_n) && mem_dout_en));

    // R5: data still driven when the write strobe rises
    a_r5_hold_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dout_en);

    // R9: protected write refused next cycle without a strobe
    a_r9_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && wprot) |=> (done && done_err && mem_we_n));

endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(
    .ADDR_W(ADDR_W),
    .RD_CYC(RD_CYC),
    .WP_CYC(WP_CYC),
    .TA_CYC(TA_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_ready  (req_ready),
    .wprot      (wprot),
    .done       (done),
    .done_err   (done_err),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dout_en(mem_dout_en),
    .mem_addr   (mem_addr)
);

// File: tb/sim_sram_seq_ctrl.sv
module sim_sram_seq_ctrl;

    localparam int CLK_NS = 10;
    localparam int AW     = 11;
    localparam int DW     = 8;
    localparam int DEPTH  = 1 << AW;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
    function automatic logic [DW-1:0] fill(input int a);
        return DW'((a * 37) ^ (a >> 3) ^ 8'h5A);
    endfunction

    localparam int RD  = mx(mx(cyc(100), cyc(50)), cyc(100));
    localparam int WP  = mx(cyc(75), cyc(40));
    localparam int REC = mx(cyc(10), cyc(100) - WP - 1);
    localparam int TA  = mx(cyc(35), cyc(100) - RD);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          wprot = 1'b0;
    logic          req_ready, done, done_err;
    logic [DW-1:0] rd_data, mem_dout, mem_din;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_we_n, mem_oe_n, mem_dout_en;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] ram     [DEPTH];
    logic [DW-1:0] exp_ram [DEPTH];

    sram_seq_ctrl #(.CLK_NS(CLK_NS)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .wprot(wprot),
        .req_ready(req_ready), .done(done), .done_err(done_err), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .mem_din(mem_din)
    );

    always #(CLK_NS / 2) clk = ~clk;

    // Behavioral RAM: drives only for a proper read
    assign mem_din = (!mem_ce_n && !mem_oe_n && mem_we_n) ? ram[mem_addr] : 8'hEE;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Falling-edge monitor: strobes, contention, RAM writes
    bit mon_on = 1'b0;
    bit ram_ready = 1'b0;
    bit prev_we_low = 1'b0;
    bit run_wr = 1'b0;
    int ce_run = 0;
    int since_oe = 1000;
    int we_falls = 0;

    always @(negedge clk) begin
        if (!ram_ready) begin
            for (int i = 0; i < DEPTH; i++) ram[i] = fill(i);
            ram_ready = 1'b1;
        end
        if (mon_on) begin
            if (!mem_we_n && !mem_oe_n) chk(0, "R6 we/oe overlap", 1, 0);
            if (mem_dout_en && !mem_oe_n) chk(0, "R6 drive under oe", 1, 0);
            if (!mem_oe_n) since_oe = 0;
            else if (since_oe < 1000) since_oe++;
            if (mem_dout_en && since_oe <= TA) chk(0, "R7 turnaround gap", since_oe, TA + 1);
            if (!mem_ce_n) begin
                ce_run++;
                if (!mem_we_n) run_wr = 1'b1;
            end else if (ce_run > 0) begin
                if (run_wr) chk(ce_run == WP, "R4 write strobe width", ce_run, WP);
                else        chk(ce_run == RD, "R2 read strobe width", ce_run, RD);
                ce_run = 0;
                run_wr = 1'b0;
            end
            if (!mem_we_n && !prev_we_low) we_falls++;
            if (prev_we_low && mem_we_n) begin
                chk(mem_dout_en, "R5 data held at we rise", int'(mem_dout_en), 1);
                ram[mem_addr] = mem_dout;
            end
        end
        prev_we_low = !mem_we_n;
    end

    task automatic do_cmd(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit wp, input bit poke);
        int n;
        int m;
        int falls0;
        int lat;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        wprot     = wp;
        falls0    = we_falls;
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = AW'($urandom);   // R10: scramble after acceptance
        req_wdata = DW'($urandom);
        n = 1;
        if (!(wr && wp)) chk(!req_ready, "R8 busy ready low", int'(req_ready), 0);
        while (!done && n < 200) begin
            if (poke && n == 3) begin
                req_valid = 1'b1;
                req_write = 1'b1;
                req_addr  = ~a;
                req_wdata = ~d;
                wprot     = 1'b0;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        lat = (wr && wp) ? 1 : (wr ? WP + REC + 2 : RD + 1);
        chk(n == lat, wr ? (wp ? "R9 refuse latency" : "R5 write latency") : "R3 read latency",
            n, lat);
        chk(done_err == (wr && wp), wr ? "R9 error flag" : "R9 read ignores wprot",
            int'(done_err), int'(wr && wp));
        if (!wr) chk(rd_data == exp_ram[a], "R3 read data R10", int'(rd_data), int'(exp_ram[a]));
        if (wr) chk(req_ready, "R8 ready at write done", int'(req_ready), 1);
        if (wr && wp) chk(we_falls == falls0, "R9 no write strobe", we_falls - falls0, 0);
        if (wr && !wp) exp_ram[a] = d;
        @(negedge clk);
        chk(!done, "R3 done single pulse", int'(done), 0);
        if (!wr) begin
            m = 1;
            while (!req_ready && m < 200) begin
                @(negedge clk);
                m++;
            end
            chk(m == TA, "R7 ready after read", m, TA);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) exp_ram[i] = fill(i);
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes idle", int'({mem_ce_n, mem_we_n, mem_oe_n}), 7);
        chk(!mem_dout_en && !done && !done_err, "R1 drive/done low",
            int'({mem_dout_en, done, done_err}), 0);
        chk(req_ready, "R1 ready", int'(req_ready), 1);
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);

        // Directed corners
        do_cmd(1, 11'd0, 8'h00, 0, 0);
        do_cmd(1, 11'h7FF, 8'hFF, 0, 0);
        do_cmd(0, 11'd0, 8'h00, 0, 0);
        do_cmd(0, 11'h7FF, 8'h00, 0, 0);
        do_cmd(1, 11'd5, 8'h3C, 0, 0);       // write right after read
        do_cmd(1, 11'd5, 8'hC3, 1, 0);       // R9 protected
        do_cmd(0, 11'd5, 8'h00, 1, 0);       // R9 read under protect keeps 8'h3C
        do_cmd(1, 11'h155, 8'hA7, 0, 1);     // R8 poke during write
        do_cmd(0, ~11'h155, 8'h00, 0, 0);    // R8 poked address untouched
        do_cmd(0, 11'h155, 8'h00, 0, 1);     // R8 poke during read
        do_cmd(0, ~11'h155, 8'h00, 0, 0);
        do_cmd(1, 11'h2AA, 8'h81, 1, 0);
        do_cmd(1, 11'h2AA, 8'h18, 1, 0);
        do_cmd(0, 11'h2AA, 8'h00, 0, 0);

        // Random mix
        for (int k = 0; k < 400; k++) begin
            logic [AW-1:0] ra;
            ra = AW'($urandom_range(0, 63));
            do_cmd(1'($urandom_range(0, 1)), ra, DW'($urandom),
                   ($urandom_range(0, 4) == 0), ($urandom_range(0, 9) == 0));
        end
        for (int k = 0; k < 64; k++) do_cmd(0, AW'(k), 8'h00, 0, 0);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule